// File: doc/BRIEF.md
# Trigger and Event Number Counters

This block tracks how many level-1 triggers have been accepted since the last event-counter reset. It also counts the event-counter resets and records the bunch-crossing number at which the most recent trigger arrived. A 24-bit trigger number starts at all ones, so the first trigger after a reset reads zero. An 8-bit counter advances on every event-counter reset pulse. A free-running 12-bit bunch counter, which the bunch-counter reset pulse zeroes, is sampled on each trigger. A host-programmable 4-bit offset is added to the sample before it is stored.

The host sees the state as three 16-bit words. The trigger-number low word holds bits 15:0. The high word holds bits 23:16 in its low byte and the reset count in its high byte. The bunch word holds the captured bunch number in bits 11:0 and the offset in bits 15:12. When the stand-alone mode input is high, the host can preload the trigger number with "next trigger minus one". Outside that mode such writes have no effect. Bus decoding and serial transmission of the numbers are done elsewhere.

Top module: `trig_id_counters`

## Requirements
- R1: When `rst` is high at a clock edge, the low word becomes 0xFFFF, the high word becomes 0x00FF and the bunch word becomes 0x0000.
- R2: A trigger pulse without an event-counter reset adds one to the 24-bit trigger number, wrapping from 0xFFFFFF to 0x000000.
- R3: An event-counter reset pulse sets the trigger number to all ones and adds one to the 8-bit reset count, which wraps from 255 to 0. It overrides a trigger in the same cycle.
- R4: In stand-alone mode, a write with `wr_sel_i`=0 loads trigger-number bits 15:0 from `wr_data_i[15:0]`. A write with `wr_sel_i`=1 loads bits 23:16 from `wr_data_i[7:0]`; `wr_data_i[15:8]` does not alter the reset count. A trigger or event-counter reset in the same cycle takes precedence over the load.
- R5: With `standalone_i` low, writes with `wr_sel_i` 0 or 1 leave the trigger number unchanged. A write with `wr_sel_i`=3 changes nothing in any mode.
- R6: The bunch counter increments every clock and wraps 4095 to 0. A bunch-counter reset pulse makes it zero at the next edge. It reads zero in the first cycle after reset.
- R7: A trigger stores (bunch counter + offset) mod 4096 into bunch-word bits 11:0. The counter and offset values used are those present before the edge. Without a trigger the captured value holds.
- R8: A write with `wr_sel_i`=2 stores `wr_data_i[15:12]` as the offset in any mode. `wr_data_i[11:0]` does not change the captured bunch number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Accepted trigger pulse, one cycle per trigger |
| ecr_i | input | 1 | Event-counter reset pulse |
| bcr_i | input | 1 | Bunch-counter reset pulse |
| standalone_i | input | 1 | High enables host preload of the trigger number |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Target: 0 low word, 1 high word, 2 bunch word, 3 none |
| wr_data_i | input | 16 | Host write data |
| id_lo_o | output | 16 | Trigger number bits 15:0 |
| id_hi_o | output | 16 | Reset count in 15:8, trigger number bits 23:16 in 7:0 |
| bunch_o | output | 16 | Offset in 15:12, captured bunch number in 11:0 |

## Verification
Triggers are applied singly, back to back, and across the 24-bit wrap. These cases separate a correct increment from a stuck or doubled one and from a wrong carry into the upper byte. Event-counter resets are applied alone, together with a trigger, and 260 times in a row. This shows the override priority and the 8-bit wrap of the reset count. Preload writes are made in and out of stand-alone mode with junk in the unused data bits, and a bunch-counter run past 4095 followed by offset captures checks both the counter wrap and the modular add. A long random mix of all inputs is compared every cycle against a behavioural model to expose any priority clash that the directed cases miss.

// File: rtl/trig_id_pkg.sv
package trig_id_pkg;

    localparam int ID_W    = 24;
    localparam int ECR_W   = 8;
    localparam int BC_W    = 12;
    localparam int OFS_W   = 4;
    localparam int WORD_W  = 16;
    localparam int ID_HI_W = ID_W - WORD_W;

    typedef enum logic [1:0] {
        SEL_ID_LO = 2'd0,
        SEL_ID_HI = 2'd1,
        SEL_BUNCH = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic trig;
        logic ecr;
        logic bcr;
    } pulse_t;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [WORD_W-1:0] data;
    } host_wr_t;

    function automatic logic [WORD_W-1:0] pack_hi_word(
        input logic [ID_W-1:0]  id,
        input logic [ECR_W-1:0] ecr_n
    );
        return {ecr_n, id[ID_W-1:WORD_W]};
    endfunction

    function automatic logic [WORD_W-1:0] pack_bunch_word(
        input logic [OFS_W-1:0] ofs,
        input logic [BC_W-1:0]  bunch
    );
        return {ofs, bunch};
    endfunction

endpackage

// File: rtl/bunch_counter.sv
module bunch_counter #(
    parameter int BC_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bcr,
    output logic [BC_W-1:0] cnt_o
);

    logic [BC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || bcr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    assert_bcr_zero_R6: assert property (@(posedge clk) disable iff (rst)
        bcr |=> (cnt_o == '0));

    assert_free_run_R6: assert property (@(posedge clk) disable iff (rst)
        !bcr |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/bunch_capture.sv
module bunch_capture #(
    parameter int BC_W  = 12,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             ofs_we,
    input  logic [OFS_W-1:0] ofs_din,
    input  logic [BC_W-1:0]  cnt_i,
    output logic [BC_W-1:0]  bunch_o,
    output logic [OFS_W-1:0] ofs_o
);

    logic [BC_W-1:0]  bunch_q;
    logic [OFS_W-1:0] ofs_q;
    logic [BC_W-1:0]  shifted;

    assign shifted = cnt_i + BC_W'(ofs_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bunch_q <= '0;
            ofs_q   <= '0;
        end else begin
            if (trig)   bunch_q <= shifted;
            if (ofs_we) ofs_q   <= ofs_din;
        end
    end

    assign bunch_o = bunch_q;
    assign ofs_o   = ofs_q;

    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> ((bunch_o - $past(ofs_o)) == $past(cnt_i)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(bunch_o));

    assert_offset_R8: assert property (@(posedge clk) disable iff (rst)
        ofs_we |=> (ofs_o == $past(ofs_din)));

endmodule

// File: rtl/event_id_counter.sv
module event_id_counter
    import trig_id_pkg::*;
#(
    parameter int ID_W   = trig_id_pkg::ID_W,
    parameter int ECR_W  = trig_id_pkg::ECR_W,
    parameter int WORD_W = trig_id_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              ecr,
    input  logic              standalone,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] din,
    output logic [ID_W-1:0]   id_o,
    output logic [ECR_W-1:0]  ecr_cnt_o
);

    localparam int HI_W = ID_W - WORD_W;

    logic [ID_W-1:0]  id_q;
    logic [ECR_W-1:0] n_q;
    logic             load_lo;
    logic             load_hi;

    assign load_lo = wr_lo && standalone;
    assign load_hi = wr_hi && standalone;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '1;
            n_q  <= '0;
        end else if (ecr) begin
            id_q <= '1;
            n_q  <= n_q + 1'b1;
        end else if (trig) begin
            id_q <= id_q + 1'b1;
        end else if (load_lo) begin
            id_q[WORD_W-1:0] <= din;
        end else if (load_hi) begin
            id_q[ID_W-1:WORD_W] <= din[HI_W-1:0];
        end
    end

    assign id_o      = id_q;
    assign ecr_cnt_o = n_q;

    assert_trig_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (trig && !ecr) |=> (id_o == $past(id_o) + 1'b1));

    assert_ecr_R3: assert property (@(posedge clk) disable iff (rst)
        ecr |=> ((&id_o) && (ecr_cnt_o == $past(ecr_cnt_o) + 1'b1)));

    assert_count_only_ecr_R3: assert property (@(posedge clk) disable iff (rst)
        !ecr |=> $stable(ecr_cnt_o));

    assert_load_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (standalone && wr_lo && !trig && !ecr) |=> (id_o[WORD_W-1:0] == $past(din)));

    assert_no_load_R5: assert property (@(posedge clk) disable iff (rst)
        (!standalone && !trig && !ecr) |=> $stable(id_o));

endmodule

// File: rtl/trig_id_counters.sv
module trig_id_counters
    import trig_id_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_i,
    input  logic        ecr_i,
    input  logic        bcr_i,
    input  logic        standalone_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] id_lo_o,
    output logic [15:0] id_hi_o,
    output logic [15:0] bunch_o
);

    pulse_t            pulse;
    host_wr_t          wr;
    logic [ID_W-1:0]   id;
    logic [ECR_W-1:0]  ecr_n;
    logic [BC_W-1:0]   bcnt;
    logic [BC_W-1:0]   bunch;
    logic [OFS_W-1:0]  ofs;
    logic              wr_lo;
    logic              wr_hi;
    logic              wr_bunch;

    assign pulse = '{trig: trig_i, ecr: ecr_i, bcr: bcr_i};
    assign wr    = '{en: wr_en_i, sel: reg_sel_e'(wr_sel_i), data: wr_data_i};

    assign wr_lo    = wr.en && (wr.sel == SEL_ID_LO);
    assign wr_hi    = wr.en && (wr.sel == SEL_ID_HI);
    assign wr_bunch = wr.en && (wr.sel == SEL_BUNCH);

    bunch_counter #(.BC_W(BC_W)) u_bcnt (
        .clk   (clk),
        .rst   (rst),
        .bcr   (pulse.bcr),
        .cnt_o (bcnt)
    );

    bunch_capture #(.BC_W(BC_W), .OFS_W(OFS_W)) u_bcap (
        .clk     (clk),
        .rst     (rst),
        .trig    (pulse.trig),
        .ofs_we  (wr_bunch),
        .ofs_din (wr.data[WORD_W-1 -: OFS_W]),
        .cnt_i   (bcnt),
        .bunch_o (bunch),
        .ofs_o   (ofs)
    );

    event_id_counter #(.ID_W(ID_W), .ECR_W(ECR_W), .WORD_W(WORD_W)) u_evid (
        .clk        (clk),
        .rst        (rst),
        .trig       (pulse.trig),
        .ecr        (pulse.ecr),
        .standalone (standalone_i),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .din        (wr.data),
        .id_o       (id),
        .ecr_cnt_o  (ecr_n)
    );

    assign id_lo_o = id[WORD_W-1:0];
    assign id_hi_o = pack_hi_word(id, ecr_n);
    assign bunch_o = pack_bunch_word(ofs, bunch);

    assert_hi_byte_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !ecr_i) |=> $stable(id_hi_o[15:8]));

endmodule

// File: tb/trig_id_counters_tb.sv
`timescale 1ns/1ps
module trig_id_counters_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0, ecr_i = 1'b0, bcr_i = 1'b0;
    logic        standalone_i = 1'b0, wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd3;
    logic [15:0] wr_data_i = '0;
    logic [15:0] id_lo_o, id_hi_o, bunch_o;

    always #4 clk = ~clk;

    trig_id_counters u_dut (
        .clk(clk), .rst(rst), .trig_i(trig_i), .ecr_i(ecr_i), .bcr_i(bcr_i),
        .standalone_i(standalone_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .id_lo_o(id_lo_o), .id_hi_o(id_hi_o), .bunch_o(bunch_o)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    valid = 0;
    bit    done = 0;

    int m_id, m_ecr, m_bcnt, m_bunch, m_ofs;

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(int'(id_lo_o), m_id & 32'hFFFF, "low word");
        chk(int'(id_hi_o), ((m_ecr & 255) << 8) | ((m_id >> 16) & 255), "high word");
        chk(int'(bunch_o), (m_ofs << 12) | m_bunch, "bunch word");
    endtask

    task automatic step(input logic r, input logic t, input logic e, input logic b,
                        input logic sa, input logic w, input logic [1:0] s,
                        input logic [15:0] d);
        int nb;
        @(negedge clk);
        if (valid) compare();
        rst = r; trig_i = t; ecr_i = e; bcr_i = b;
        standalone_i = sa; wr_en_i = w; wr_sel_i = s; wr_data_i = d;
        if (r) begin
            m_id = 32'hFFFFFF; m_ecr = 0; m_bcnt = 0; m_bunch = 0; m_ofs = 0;
            valid = 1;
        end else begin
            nb = m_bunch;
            if (t) nb = (m_bcnt + m_ofs) % 4096;
            if (w && s == 2'd2) m_ofs = int'(d) >> 12;
            if (e) begin
                m_id  = 32'hFFFFFF;
                m_ecr = (m_ecr + 1) % 256;
            end else if (t) begin
                m_id = (m_id + 1) % 32'h1000000;
            end else if (w && sa && s == 2'd0) begin
                m_id = (m_id & 32'hFF0000) | int'(d);
            end else if (w && sa && s == 2'd1) begin
                m_id = (m_id & 32'h00FFFF) | ((int'(d) & 255) << 16);
            end
            m_bcnt  = b ? 0 : (m_bcnt + 1) % 4096;
            m_bunch = nb;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 2'd3, 16'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tag = "watchdog";
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset values
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 1, 2'd2, 16'hF123);
        chk(int'(id_lo_o), 32'hFFFF, "reset low word");
        chk(int'(id_hi_o), 32'h00FF, "reset high word");
        chk(int'(bunch_o), 32'h0000, "reset bunch word");
        idle(3);

        // R2: single and back-to-back triggers
        tag = "R2";
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        idle(2);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        idle(1);

        // R6: bunch counter wrap and reset pulses
        tag = "R6";
        step(0, 0, 0, 1, 0, 0, 2'd3, 0);
        idle(4100);
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        step(0, 0, 0, 1, 0, 0, 2'd3, 0);
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        idle(2);

        // R8: offset write with junk low bits, both modes
        tag = "R8";
        step(0, 0, 0, 0, 0, 1, 2'd2, 16'h5ABC);
        idle(1);
        step(0, 0, 0, 0, 1, 1, 2'd2, 16'hF777);
        idle(1);

        // R7: capture with offset, including modular wrap and write-same-cycle
        tag = "R7";
        step(0, 0, 0, 1, 0, 0, 2'd3, 0);
        idle(4090);
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        step(0, 1, 0, 0, 0, 1, 2'd2, 16'h3000);
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        idle(2);

        // R3: event-counter reset, with trigger, and count wrap
        tag = "R3";
        step(0, 0, 1, 0, 0, 0, 2'd3, 0);
        step(0, 1, 0, 0, 0, 0, 2'd3, 0);
        step(0, 1, 1, 0, 0, 0, 2'd3, 0);
        for (int i = 0; i < 260; i++) step(0, 0, 1, 0, 0, 0, 2'd3, 0);
        idle(1);

        // R4: preload in stand-alone mode, junk in high byte, precedence
        tag = "R4";
        step(0, 0, 0, 0, 1, 1, 2'd0, 16'hFFFE);
        step(0, 0, 0, 0, 1, 1, 2'd1, 16'hA5FF);
        step(0, 1, 0, 0, 1, 0, 2'd3, 0);
        step(0, 1, 0, 0, 1, 0, 2'd3, 0);
        step(0, 1, 0, 0, 1, 0, 2'd3, 0);
        step(0, 1, 0, 0, 1, 1, 2'd0, 16'h1234);
        step(0, 0, 1, 0, 1, 1, 2'd1, 16'h0042);
        step(0, 0, 0, 0, 1, 1, 2'd1, 16'hEE42);
        step(0, 0, 0, 0, 1, 1, 2'd0, 16'h9876);
        idle(1);

        // R5: preload ignored outside stand-alone mode, select 3 ignored
        tag = "R5";
        step(0, 0, 0, 0, 0, 1, 2'd0, 16'h0000);
        step(0, 0, 0, 0, 0, 1, 2'd1, 16'h0011);
        step(0, 0, 0, 0, 1, 1, 2'd3, 16'hFFFF);
        step(0, 0, 0, 0, 0, 1, 2'd3, 16'h0000);
        idle(1);

        // mixed random traffic against the model (R2 R3 R4 R7)
        tag = "mix";
        for (int i = 0; i < 3000; i++) begin
            step(0, ($urandom_range(0, 3) == 0), ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 31) == 0), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)),
                 16'($urandom));
        end

        // R1: reset from a busy state
        tag = "R1";
        step(1, 0, 0, 0, 0, 0, 2'd3, 0);
        idle(2);
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule